// File: doc/BRIEF.md
# Hash-Based Queue Spreader

This block turns a 64-bit flow hash into a 24-bit destination queue identifier. Each ingress port has a 32-bit partition mask that names the spreading schemes the port may use. Each scheme has three configuration words: a mode word that enables it, a hash command word, and a base queue identifier. The hash command word gives a right-shift amount and a queue-range mask.

When a valid hash arrives, the block picks the lowest-numbered scheme that is both in the port's partition and enabled. It shifts the hash right and keeps the low 24 bits. It then masks that slice down to the scheme's power-of-two range and adds the scheme's aligned base. The result is registered. If no enabled scheme matches, the block reports a drop instead of a queue. Computing the hash and parsing the packet are done upstream. The configuration arrives as static input vectors.

Top module: `qspread`

## Requirements
- R1: Scheme n belongs to a port's partition exactly when bit (31 - n) of that port's 32-bit partition mask is set. The mask used is the one selected by `in_port`.
- R2: A scheme is eligible only when bit 31 of its mode word is 1. The other mode bits have no effect. A partitioned scheme whose bit 31 is 0 is skipped.
- R3: When several schemes are both partitioned and enabled, the lowest-numbered one is used.
- R4: When no scheme is both partitioned and enabled, the result carries `res_drop`=1 and `res_qid`=0.
- R5: The hash slice is (hash >> s), truncated to its low 24 bits, with zeros shifted in from the top. Here s is bits [29:24] of the hash command word. A shift of 0 selects hash bits [23:0].
- R6: The queue identifier is (slice AND cmd[23:0]) + base, taken modulo 2^24. Here cmd[23:0] holds the queue range minus one.
- R7: Bit 30 of the hash command word (the symmetric-hash option) does not change the queue identifier.
- R8: `res_valid` is 1 exactly in the cycle after a cycle with `in_valid`=1. While `res_valid` is 0, `res_drop` and `res_qid` are 0.
- R9: While `rst` is high, and in the first cycle after it falls, `res_valid`, `res_drop` and `res_qid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_hash` and `in_port` |
| in_port | input | PORT_W | Ingress port index |
| in_hash | input | 64 | Flow hash |
| part_masks | input | NUM_PORTS*32 | Partition mask per port, port p at bits [32p+31:32p] |
| scheme_mode | input | NUM_SCHEMES*32 | Mode word per scheme, bit 31 enables |
| scheme_hcmd | input | NUM_SCHEMES*32 | Hash command per scheme: [29:24] shift, [23:0] range-1, [30] symmetric |
| scheme_base | input | NUM_SCHEMES*24 | Base queue identifier per scheme |
| res_valid | output | 1 | Result valid, one cycle after `in_valid` |
| res_drop | output | 1 | No eligible scheme matched |
| res_qid | output | 24 | Destination queue identifier |

## Verification
On every cycle, the checker checks the result timing against `in_valid`, the quiet outputs when no result is valid, the clearing done by reset, and the fact that a drop carries a zero queue. It also derives, from the port's mask and the mode words, whether a drop or a hit must follow, and checks that the result agrees.

The exact queue arithmetic can only be shown by the bench's scenarios. These scenarios cover shifts of 0, 8, 40 and 63, several range sizes, wrap at the top of the queue space, the choice among several candidate schemes, the skipping of a disabled scheme, and the symmetric bit having no effect.

// File: rtl/qspread_pkg.sv
package qspread_pkg;
    localparam int HASH_W    = 64;
    localparam int QID_W     = 24;
    localparam int WORD_W    = 32;
    localparam int EN_BIT    = 31;
    localparam int SHAMT_LSB = 24;
    localparam int SHAMT_W   = 6;

    typedef struct packed {
        logic             drop;
        logic [QID_W-1:0] qid;
    } qs_result_t;

    function automatic logic [QID_W-1:0] hash_slice(input logic [HASH_W-1:0] h,
                                                    input logic [SHAMT_W-1:0] s);
        logic [HASH_W-1:0] shifted;
        shifted = h >> s;
        return shifted[QID_W-1:0];
    endfunction

    function automatic logic [SHAMT_W-1:0] cmd_shamt(input logic [WORD_W-1:0] cmd);
        return cmd[SHAMT_LSB +: SHAMT_W];
    endfunction
endpackage

// File: rtl/qspread_pick.sv
module qspread_pick #(
    parameter int NUM_SCHEMES = 8,
    localparam int IDX_W = $clog2(NUM_SCHEMES)
) (
    input  logic [31:0]            part_mask,
    input  logic [NUM_SCHEMES-1:0] sch_en,
    output logic                   hit,
    output logic [IDX_W-1:0]       idx
);
    logic [NUM_SCHEMES-1:0] cand;

    generate
        for (genvar n = 0; n < NUM_SCHEMES; n++) begin : g_cand
            assign cand[n] = part_mask[31-n] & sch_en[n];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int n = NUM_SCHEMES - 1; n >= 0; n--) begin
            if (cand[n]) idx = IDX_W'(n);
        end
        hit = |cand;
    end

    logic unused_mask_bits;
    generate
        if (NUM_SCHEMES < 32) begin : g_unused
            assign unused_mask_bits = ^part_mask[31-NUM_SCHEMES:0];
        end else begin : g_full
            assign unused_mask_bits = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/qspread_calc.sv
module qspread_calc
    import qspread_pkg::*;
(
    input  logic [HASH_W-1:0] hash,
    input  logic [WORD_W-1:0] hcmd,
    input  logic [QID_W-1:0]  base,
    output logic [QID_W-1:0]  qid
);
    logic [QID_W-1:0] slice;
    logic             unused_cmd_bits;

    assign slice           = hash_slice(hash, cmd_shamt(hcmd));
    assign qid             = (slice & hcmd[QID_W-1:0]) + base;
    assign unused_cmd_bits = ^hcmd[WORD_W-1:SHAMT_LSB+SHAMT_W];
endmodule

// File: rtl/qspread.sv
module qspread
    import qspread_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int NUM_SCHEMES = 8,
    localparam int PORT_W = $clog2(NUM_PORTS),
    localparam int IDX_W  = $clog2(NUM_SCHEMES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [PORT_W-1:0]             in_port,
    input  logic [HASH_W-1:0]             in_hash,
    input  logic [NUM_PORTS*WORD_W-1:0]   part_masks,
    input  logic [NUM_SCHEMES*WORD_W-1:0] scheme_mode,
    input  logic [NUM_SCHEMES*WORD_W-1:0] scheme_hcmd,
    input  logic [NUM_SCHEMES*QID_W-1:0]  scheme_base,
    output logic                          res_valid,
    output logic                          res_drop,
    output logic [QID_W-1:0]              res_qid
);
    logic [WORD_W-1:0]      mask_arr [NUM_PORTS];
    logic [WORD_W-1:0]      hcmd_arr [NUM_SCHEMES];
    logic [QID_W-1:0]       base_arr [NUM_SCHEMES];
    logic [NUM_SCHEMES-1:0] sch_en;
    logic [NUM_SCHEMES-1:0] unused_mode;

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            assign mask_arr[p] = part_masks[p*WORD_W +: WORD_W];
        end
        for (genvar n = 0; n < NUM_SCHEMES; n++) begin : g_sch
            assign hcmd_arr[n]    = scheme_hcmd[n*WORD_W +: WORD_W];
            assign base_arr[n]    = scheme_base[n*QID_W +: QID_W];
            assign sch_en[n]      = scheme_mode[n*WORD_W + EN_BIT];
            assign unused_mode[n] = ^scheme_mode[n*WORD_W +: EN_BIT];
        end
    endgenerate

    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [QID_W-1:0] qid_c;

    qspread_pick #(.NUM_SCHEMES(NUM_SCHEMES)) u_pick (
        .part_mask (mask_arr[in_port]),
        .sch_en    (sch_en),
        .hit       (hit),
        .idx       (idx)
    );

    qspread_calc u_calc (
        .hash (in_hash),
        .hcmd (hcmd_arr[idx]),
        .base (base_arr[idx]),
        .qid  (qid_c)
    );

    qs_result_t res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            res_valid <= in_valid;
            if (in_valid && hit)  res_q <= '{drop: 1'b0, qid: qid_c};
            else if (in_valid)    res_q <= '{drop: 1'b1, qid: '0};
            else                  res_q <= '0;
        end
    end

    assign res_drop = res_q.drop;
    assign res_qid  = res_q.qid;
endmodule

// File: rtl/qspread_chk.sv
module qspread_chk #(
    parameter int NUM_PORTS   = 4,
    parameter int NUM_SCHEMES = 8,
    localparam int PORT_W = $clog2(NUM_PORTS)
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      in_valid,
    input logic [PORT_W-1:0]         in_port,
    input logic [NUM_PORTS*32-1:0]   part_masks,
    input logic [NUM_SCHEMES*32-1:0] scheme_mode,
    input logic                      res_valid,
    input logic                      res_drop,
    input logic [23:0]               res_qid
);
    logic [31:0] sel_mask;
    logic        any_cand;

    always_comb begin
        sel_mask = '0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (in_port == PORT_W'(p)) sel_mask = part_masks[p*32 +: 32];
        any_cand = 1'b0;
        for (int n = 0; n < NUM_SCHEMES; n++)
            if (sel_mask[31-n] && scheme_mode[n*32+31]) any_cand = 1'b1;
    end

    // R8
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);
    // R8
    valid_source_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(in_valid));
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!res_drop && res_qid == 24'd0));
    // R4
    drop_zero_chk: assert property (@(posedge clk) disable iff (rst)
        res_drop |-> res_qid == 24'd0);
    // R4
    nomatch_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !any_cand) |=> res_drop);
    // R2
    match_nodrop_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && any_cand) |=> !res_drop);
    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!res_valid && !res_drop));
endmodule

bind qspread qspread_chk #(.NUM_PORTS(NUM_PORTS), .NUM_SCHEMES(NUM_SCHEMES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_port     (in_port),
    .part_masks  (part_masks),
    .scheme_mode (scheme_mode),
    .res_valid   (res_valid),
    .res_drop    (res_drop),
    .res_qid     (res_qid)
);

// File: tb/qspread_tb.sv
module qspread_tb;
    localparam int NP = 4;
    localparam int NS = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [1:0]     in_port = '0;
    logic [63:0]    in_hash = '0;
    logic [NP*32-1:0] part_masks = '0;
    logic [NS*32-1:0] scheme_mode = '0;
    logic [NS*32-1:0] scheme_hcmd = '0;
    logic [NS*24-1:0] scheme_base = '0;
    logic           res_valid, res_drop;
    logic [23:0]    res_qid;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    qspread #(.NUM_PORTS(NP), .NUM_SCHEMES(NS)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_port(in_port),
        .in_hash(in_hash), .part_masks(part_masks), .scheme_mode(scheme_mode),
        .scheme_hcmd(scheme_hcmd), .scheme_base(scheme_base),
        .res_valid(res_valid), .res_drop(res_drop), .res_qid(res_qid)
    );

    typedef struct packed {
        logic [1:0]  port;
        logic [63:0] hash;
        logic        drop;
        logic [23:0] qid;
    } vec_t;

    // R1 R3 R5 R6 R2 R4 scenarios
    localparam vec_t VECS [7] = '{
        '{2'd0, 64'h0123_4567_89AB_CDEF, 1'b0, 24'h00010F},
        '{2'd0, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 24'h000100},
        '{2'd1, 64'h0000_0000_0000_0300, 1'b0, 24'h000203},
        '{2'd1, 64'h0000_0000_0000_02FF, 1'b0, 24'h000202},
        '{2'd2, 64'h0000_AB00_0000_0000, 1'b0, 24'h0010AB},
        '{2'd2, 64'hFFFF_FF00_0000_0000, 1'b0, 24'h0010FF},
        '{2'd3, 64'h1234_5678_9ABC_DEF0, 1'b1, 24'h000000}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic set_scheme(input int n, input logic en, input logic sym,
                              input logic [5:0] sh, input logic [23:0] m1,
                              input logic [23:0] base);
        scheme_mode[n*32 +: 32] = {en, 31'h0000_00A5};
        scheme_hcmd[n*32 +: 32] = {1'b0, sym, sh, m1};
        scheme_base[n*24 +: 24] = base;
    endtask

    task automatic run(input logic [1:0] port, input logic [63:0] hash,
                       input logic exp_drop, input logic [23:0] exp_qid, input string tag);
        @(negedge clk);
        in_port  = port;
        in_hash  = hash;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " valid R8"}, {31'd0, res_valid}, 32'd1);
        chk({tag, " drop"}, {31'd0, res_drop}, {31'd0, exp_drop});
        chk({tag, " qid"}, {8'd0, res_qid}, {8'd0, exp_qid});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        set_scheme(0, 1'b1, 1'b0, 6'd0,  24'h00000F, 24'h000100);
        set_scheme(1, 1'b1, 1'b1, 6'd8,  24'h000003, 24'h000200);
        set_scheme(2, 1'b0, 1'b0, 6'd0,  24'h000000, 24'h000300);
        set_scheme(3, 1'b1, 1'b0, 6'd40, 24'h0000FF, 24'h001000);
        set_scheme(7, 1'b1, 1'b0, 6'd63, 24'h000001, 24'hFFFFFE);
        part_masks[0*32 +: 32] = 32'h8000_0000;
        part_masks[1*32 +: 32] = 32'h5000_0000;
        part_masks[2*32 +: 32] = 32'h3000_0000;
        part_masks[3*32 +: 32] = 32'h2000_0000;

        // R9: reset state, with in_valid high during reset
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk("reset valid R9", {31'd0, res_valid}, 32'd0);
        chk("reset qid R9", {8'd0, res_qid}, 32'd0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("post-reset valid R9", {31'd0, res_valid}, 32'd0);
        chk("post-reset drop R9", {31'd0, res_drop}, 32'd0);

        for (int i = 0; i < 7; i++)
            run(VECS[i].port, VECS[i].hash, VECS[i].drop, VECS[i].qid, $sformatf("vec%0d R5 R6", i));

        // R8: idle cycle after a result
        @(negedge clk);
        chk("idle valid R8", {31'd0, res_valid}, 32'd0);
        chk("idle qid R8", {8'd0, res_qid}, 32'd0);

        // R7: clearing the symmetric bit leaves the result unchanged
        scheme_hcmd[1*32+30] = 1'b0;
        run(2'd1, 64'h0000_0000_0000_0300, 1'b0, 24'h000203, "sym off R7");

        // R1: scheme 7 reached via bit 24; R6 wrap at top of queue space
        part_masks[3*32 +: 32] = 32'h0100_0000;
        run(2'd3, 64'h8000_0000_0000_0000, 1'b0, 24'hFFFFFF, "shift63 R1 R6");
        run(2'd3, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 24'hFFFFFE, "shift63 low R5");
        scheme_base[7*24 +: 24] = 24'hFFFFFF;
        run(2'd3, 64'h8000_0000_0000_0000, 1'b0, 24'h000000, "wrap R6");

        // R4: empty partition drops
        part_masks[3*32 +: 32] = 32'h0000_0000;
        run(2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 24'h000000, "empty mask R4");

        // R2: disabling scheme 1 makes port 1 fall to scheme 3
        scheme_mode[1*32+31] = 1'b0;
        run(2'd1, 64'h0000_0500_0000_0300, 1'b0, 24'h001005, "disabled skip R2 R3");

        // R3: enabling scheme 2 makes port 2 use it over scheme 3
        scheme_mode[2*32+31] = 1'b1;
        run(2'd2, 64'h0000_AB00_0000_0000, 1'b0, 24'h000300, "lowest wins R3");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule